// File: doc/BRIEF.md
# SMBus Register Access Target

This block is a target on a two-wire SMBus segment that gives a host byte-wide access to a small bank of configuration registers. It samples the clock and data lines with the system clock through two-flop synchronisers. It finds edges and START/STOP conditions by comparing each sample with the one before it. It shifts bytes in and out most significant bit first. It pulls the data line low through an open-drain enable. A write carries the device address, a register pointer and one data byte. A read sets the pointer the same way, then sends a repeated START and the device address with the read bit, and the target returns one byte.

Alongside the transfer logic, a timer marks the bus as idle. It does so when both lines have stayed high for a bus-free time after a STOP, or for a longer maximum clock-high time whatever came before. The register contents are brought out as a flat configuration vector for the logic the block controls. Each register has a reset value and can be marked read-only by a parameter mask.

Top module: `smb_regtarget`

## Requirements
- R1: After reset, sda_oe is 0, bus_idle is 0 and cfg_out equals RESET_VALS. Register i occupies cfg_out bits [8i+7:8i].
- R2: START (SDA falling while SCL high) and STOP (SDA rising while SCL high) are recognised at any bit position. A START aborts the current byte and restarts address reception. A STOP releases SDA and makes the target wait for the next START. A byte cut short by either condition changes no register.
- R3: The first byte after a START is the 7-bit device address MSB first, followed by the direction bit (0 = write, 1 = read). On a match with DEV_ADDR the target holds SDA low (sda_oe = 1) throughout the ninth clock. On a mismatch it never drives SDA until the next START.
- R4: In a write-direction transfer, the second byte is acknowledged and latched as the register pointer. The pointer is kept across a repeated START.
- R5: The third byte of a write is acknowledged and stored into the register the pointer selects, and it appears on cfg_out.
- R6: A write to a register whose bit in RO_MASK is 1 is acknowledged and leaves the register at its reset value.
- R7: After a matching address with the direction bit 1 and its acknowledge, the target sends the selected register MSB first, one bit per SCL clock. It drives sda_oe = 1 for each 0 bit and releases SDA for the host's acknowledge bit.
- R8: A pointer of NREG or above reads as 0x00, and a data byte written to it is acknowledged and discarded.
- R9: sda_oe changes only while the synchronised SCL is low.
- R10: bus_idle rises once both lines have been high for T_BUF cycles after a STOP, or for T_HIGH_MAX cycles otherwise. It falls as soon as either line is seen low.
- R11: Data bytes after the first in a write transfer are not acknowledged and are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad (includes this target's own pull-down) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| bus_idle | output | 1 | Bus has been free long enough to count as idle |
| cfg_out | output | NREG*8 | Contents of all registers, register 0 in the low byte |

## Verification
The bench builds the block with DEV_ADDR 0x2C, eight registers and read-only mask 0x84, so registers 2 and 7 are fixed. It sets the bus-free time to 20 cycles and the maximum clock-high time to 60 cycles. With these short timeouts, both ways into the idle state and the way out of it are reached within a few hundred cycles, next to full bit-level transfers. The eight registers leave pointer 0x20 outside the bank, so unimplemented reads and discarded writes are exercised too. A behavioural register and pointer model in the bench is compared with cfg_out on every clock between transfers.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_DEVADR,
    ST_POINTER,
    ST_WRBYTE,
    ST_ACKSLOT,
    ST_RDBYTE,
    ST_SKIP
  } tgt_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int T_BUF      = 500,
  parameter int T_HIGH_MAX = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic start_det,
  input  logic stop_det,
  output logic bus_idle
);

  localparam int CW = $clog2(T_HIGH_MAX + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(T_HIGH_MAX);
  localparam logic [CW-1:0] BUF_LIM  = CW'(T_BUF - 1);
  localparam logic [CW-1:0] HIGH_LIM = CW'(T_HIGH_MAX - 1);

  logic [CW-1:0] high_cnt;
  logic          after_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_cnt   <= '0;
      after_stop <= 1'b0;
      bus_idle   <= 1'b0;
    end else begin
      if (start_det)
        after_stop <= 1'b0;
      else if (stop_det)
        after_stop <= 1'b1;

      if (!(scl_s && sda_s)) begin
        high_cnt <= '0;
        bus_idle <= 1'b0;
      end else begin
        if (high_cnt != CNT_MAX)
          high_cnt <= high_cnt + 1'b1;
        if ((after_stop && high_cnt >= BUF_LIM) || high_cnt >= HIGH_LIM)
          bus_idle <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int               NREG       = 8,
  parameter logic [NREG-1:0]  RO_MASK    = '0,
  parameter logic [NREG*8-1:0] RESET_VALS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ptr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_out
);

  logic [NREG*8-1:0] store;

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= RESET_VALS;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (ptr == 8'(i) && !RO_MASK[i])
          store[i*8 +: 8] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (ptr == 8'(i))
        rd_data = store[i*8 +: 8];
    end
  end

  assign cfg_out = store;

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_bit,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data
);

  tgt_state_t state;
  tgt_state_t after_ack;
  logic       ack_on;
  logic [3:0] bcnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic [7:0] nb;

  assign nb = {shreg[6:0], sda_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      after_ack <= ST_SKIP;
      ack_on    <= 1'b0;
      bcnt      <= '0;
      shreg     <= '0;
      tx        <= '0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_DEVADR;
        bcnt   <= '0;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_WAIT;
        ack_on <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEVADR, ST_POINTER, ST_WRBYTE: begin
            if (scl_rise) begin
              shreg <= nb;
              if (bcnt == 4'd7) begin
                bcnt <= '0;
                if (state == ST_DEVADR) begin
                  if (nb[7:1] == DEV_ADDR) begin
                    state     <= ST_ACKSLOT;
                    after_ack <= nb[0] ? ST_RDBYTE : ST_POINTER;
                  end else begin
                    state <= ST_SKIP;
                  end
                end else if (state == ST_POINTER) begin
                  ptr       <= nb;
                  state     <= ST_ACKSLOT;
                  after_ack <= ST_WRBYTE;
                end else begin
                  wr_en     <= 1'b1;
                  wr_data   <= nb;
                  state     <= ST_ACKSLOT;
                  after_ack <= ST_SKIP;
                end
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end
          ST_ACKSLOT: begin
            if (scl_fall) begin
              if (!ack_on) begin
                ack_on <= 1'b1;
                sda_oe <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                state  <= after_ack;
                bcnt   <= '0;
                if (after_ack == ST_RDBYTE) begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          ST_RDBYTE: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end else begin
                sda_oe <= ~tx[3'd7 - bcnt[2:0]];
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_regtarget.sv
module smb_regtarget #(
  parameter logic [6:0]        DEV_ADDR   = 7'h2C,
  parameter int                NREG       = 8,
  parameter logic [NREG-1:0]   RO_MASK    = 8'h84,
  parameter logic [NREG*8-1:0] RESET_VALS = 64'h1716_1514_1312_1110,
  parameter int                T_BUF      = 500,
  parameter int                T_HIGH_MAX = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              bus_idle,
  output logic [NREG*8-1:0] cfg_out
);

  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic [7:0] ptr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_idle_timer #(.T_BUF(T_BUF), .T_HIGH_MAX(T_HIGH_MAX)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .bus_idle  (bus_idle)
  );

  smb_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_bit   (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data)
  );

  smb_regfile #(.NREG(NREG), .RO_MASK(RO_MASK), .RESET_VALS(RESET_VALS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ptr     (ptr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cfg_out (cfg_out)
  );

endmodule

// File: rtl/smb_regtarget_chk.sv
module smb_regtarget_chk #(
  parameter int                NREG       = 8,
  parameter logic [NREG-1:0]   RO_MASK    = '0,
  parameter logic [NREG*8-1:0] RESET_VALS = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_s,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              bus_idle,
  input logic [NREG*8-1:0] cfg_out
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_out == RESET_VALS && !sda_oe && !bus_idle));

  // R9
  oe_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_s || !sda_s) |=> !bus_idle);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (RO_MASK[i]) begin : g_ro
      // R6
      ro_keep_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_out[i*8 +: 8] == RESET_VALS[i*8 +: 8]);
    end
  end

endmodule

bind smb_regtarget smb_regtarget_chk #(
  .NREG(NREG), .RO_MASK(RO_MASK), .RESET_VALS(RESET_VALS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .sda_s    (sda_s),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .bus_idle (bus_idle),
  .cfg_out  (cfg_out)
);

// File: tb/smb_regtarget_test.sv
module smb_regtarget_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [6:0]  DEV        = 7'h2C;
  localparam logic [7:0]  RO         = 8'h84;
  localparam logic [63:0] DEFAULTS   = 64'h1716_1514_1312_1110;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_h = 1'b1;
  logic        sda_h = 1'b1;
  wire         sda_line;
  logic        sda_oe;
  logic        bus_idle;
  logic [63:0] cfg_out;

  assign sda_line = sda_h & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_regtarget #(
    .DEV_ADDR(DEV), .NREG(8), .RO_MASK(RO), .RESET_VALS(DEFAULTS),
    .T_BUF(20), .T_HIGH_MAX(60)
  ) uut (
    .clk(clk), .rst(rst), .scl_in(scl_h), .sda_in(sda_line),
    .sda_oe(sda_oe), .bus_idle(bus_idle), .cfg_out(cfg_out)
  );

  int         nchk = 0;
  int         nerr = 0;
  logic       in_txn = 1'b1;
  logic [7:0] exp_regs [8];
  logic [7:0] exp_ptr = 8'h00;
  logic       prev_oe = 1'b0;
  logic       a1, a2, a3, a4, s;
  logic [7:0] v;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = exp_regs[i];
    return f;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] p);
    return (p < 8) ? exp_regs[p[2:0]] : 8'h00;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hbit(input logic b, output logic seen);
    tick(6); sda_h = b;
    tick(6); scl_h = 1'b1;
    tick(4); seen = sda_line;
    tick(4); scl_h = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) hbit(b[i], x);
    hbit(1'b1, x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      hbit(1'b1, x);
      d[i] = x;
    end
    hbit(nack, x);
  endtask

  task automatic bus_start();
    in_txn = 1'b1;
    if (!scl_h) begin
      tick(4); sda_h = 1'b1;
      tick(4); scl_h = 1'b1;
      tick(8);
    end
    sda_h = 1'b0;
    tick(8); scl_h = 1'b0;
  endtask

  task automatic bus_stop();
    tick(6); sda_h = 1'b0;
    tick(6); scl_h = 1'b1;
    tick(8); sda_h = 1'b1;
    tick(8);
    in_txn = 1'b0;
    tick(4);
  endtask

  task automatic model_write(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d);
    if (dev == DEV) begin
      exp_ptr = ra;
      if (ra < 8 && !RO[ra[2:0]]) exp_regs[ra[2:0]] = d;
    end
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          output logic k1, output logic k2, output logic k3);
    bus_start();
    send_byte({dev, 1'b0}, k1);
    send_byte(ra, k2);
    send_byte(d, k3);
    model_write(dev, ra, d);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] ra, output logic [7:0] d,
                         output logic k1, output logic k2, output logic k3);
    bus_start();
    send_byte({DEV, 1'b0}, k1);
    send_byte(ra, k2);
    exp_ptr = ra;
    bus_start();
    send_byte({DEV, 1'b1}, k3);
    recv_byte(d, 1'b1);
    bus_stop();
  endtask

  // Per-clock comparison with the behavioural model outside transfers
  always @(negedge clk) begin
    if (!rst && !in_txn) begin
      chk(cfg_out == model_flat(), "R5 model cfg_out", cfg_out, model_flat());
      chk(!sda_oe, "R2 released between transfers", {63'd0, sda_oe}, 64'd0);
    end
    if (!rst) begin
      if (sda_oe !== prev_oe)
        chk(!scl_h, "R9 oe change with SCL low", {63'd0, scl_h}, 64'd0);
      prev_oe = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_regs[i] = DEFAULTS[i*8 +: 8];
    tick(5);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(!sda_oe, "R1 sda_oe after reset", {63'd0, sda_oe}, 64'd0);
    chk(!bus_idle, "R1 bus_idle after reset", {63'd0, bus_idle}, 64'd0);
    chk(cfg_out == DEFAULTS, "R1 cfg_out defaults", cfg_out, DEFAULTS);
    in_txn = 1'b0;

    // R10 idle without a preceding STOP needs T_HIGH_MAX
    tick(30);
    chk(!bus_idle, "R10 idle before max-high time", {63'd0, bus_idle}, 64'd0);
    tick(50);
    chk(bus_idle, "R10 idle after max-high time", {63'd0, bus_idle}, 64'd1);

    // R3 R4 R5 plain write
    do_write(DEV, 8'h03, 8'hC3, a1, a2, a3);
    chk(a1, "R3 address ack", {63'd0, a1}, 64'd1);
    chk(a2, "R4 pointer ack", {63'd0, a2}, 64'd1);
    chk(a3, "R5 data ack", {63'd0, a3}, 64'd1);
    chk(!bus_idle, "R10 not idle soon after STOP", {63'd0, bus_idle}, 64'd0);
    tick(20);
    chk(bus_idle, "R10 idle after bus-free time", {63'd0, bus_idle}, 64'd1);

    // R7 R4 read back through repeated START
    do_read(8'h03, v, a1, a2, a3);
    chk(a1 && a2 && a3, "R7 read acks", {61'd0, a1, a2, a3}, 64'h7);
    chk(v == 8'hC3, "R7 read data C3", {56'd0, v}, {56'd0, model_read(8'h03)});

    do_write(DEV, 8'h00, 8'hA5, a1, a2, a3);
    do_read(8'h00, v, a1, a2, a3);
    chk(v == 8'hA5, "R7 read data A5", {56'd0, v}, 64'hA5);
    do_read(8'h01, v, a1, a2, a3);
    chk(v == 8'h11, "R7 read default", {56'd0, v}, 64'h11);

    // R6 read-only register
    do_write(DEV, 8'h02, 8'hFF, a1, a2, a3);
    chk(a3, "R6 RO write acked", {63'd0, a3}, 64'd1);
    do_read(8'h02, v, a1, a2, a3);
    chk(v == 8'h12, "R6 RO value kept", {56'd0, v}, 64'h12);
    do_read(8'h07, v, a1, a2, a3);
    chk(v == 8'h17, "R6 RO reg 7 read", {56'd0, v}, 64'h17);

    // R3 address mismatch: no ack, nothing stored
    do_write(7'h2D, 8'h00, 8'hEE, a1, a2, a3);
    chk(!a1 && !a2 && !a3, "R3 mismatch not acked", {61'd0, a1, a2, a3}, 64'd0);
    do_read(8'h00, v, a1, a2, a3);
    chk(v == 8'hA5, "R3 mismatch left reg 0", {56'd0, v}, 64'hA5);

    // R8 unimplemented pointer
    do_write(DEV, 8'h20, 8'h99, a1, a2, a3);
    chk(a3, "R8 out-of-range write acked", {63'd0, a3}, 64'd1);
    do_read(8'h20, v, a1, a2, a3);
    chk(v == 8'h00, "R8 out-of-range read", {56'd0, v}, 64'h00);

    // R11 second data byte
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(8'h04, a2);
    send_byte(8'h44, a3);
    model_write(DEV, 8'h04, 8'h44);
    send_byte(8'hBB, a4);
    bus_stop();
    chk(a3, "R11 first data acked", {63'd0, a3}, 64'd1);
    chk(!a4, "R11 second data not acked", {63'd0, a4}, 64'd0);
    chk(cfg_out[39:32] == 8'h44, "R11 reg 4 keeps first byte", {56'd0, cfg_out[39:32]}, 64'h44);

    // R2 START in the middle of the address byte
    bus_start();
    hbit(1'b0, s); hbit(1'b1, s); hbit(1'b0, s);
    chk(!bus_idle, "R10 cleared during transfer", {63'd0, bus_idle}, 64'd0);
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(8'h05, a2);
    send_byte(8'h5A, a3);
    model_write(DEV, 8'h05, 8'h5A);
    bus_stop();
    chk(a1 && a2 && a3, "R2 restart then write acks", {61'd0, a1, a2, a3}, 64'h7);
    chk(cfg_out[47:40] == 8'h5A, "R2 write after restart", {56'd0, cfg_out[47:40]}, 64'h5A);

    // R2 STOP in the middle of the pointer byte
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    hbit(1'b0, s); hbit(1'b0, s); hbit(1'b0, s); hbit(1'b0, s);
    bus_stop();
    chk(cfg_out == model_flat(), "R2 aborted byte changes nothing", cfg_out, model_flat());
    do_write(DEV, 8'h06, 8'h66, a1, a2, a3);
    chk(a1 && a2 && a3, "R2 write after abort acks", {61'd0, a1, a2, a3}, 64'h7);
    do_read(8'h06, v, a1, a2, a3);
    chk(v == 8'h66, "R2 read after abort", {56'd0, v}, 64'h66);

    tick(10);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule